// File: doc/BRIEF.md
# Instrument-Bus Command Decoder and Crate Register Loader

This block sits at the receiving end of a bridge between a parallel instrument bus and a crate dataway. It takes part in the three-wire acceptor handshake for every byte on the bus. When attention (ATN) is true, it reads each byte as an interface command and steps a four-state mode machine through idle, listen, talk and serial poll. Its bus address comes from five switch inputs.

While the block is addressed to listen, the first data byte is sorted by its class field. The class is one of three kinds. A module function code starts a fixed loading sequence: subaddress, station and three write-data bytes. A global control byte sets or clears the clear, initialize and inhibit latches. A setup byte is held until the controller sends unlisten and is only committed then; it never starts a crate cycle. Loading may stop after any byte, and a register that is not reloaded keeps its value.

The latched registers and mode flags drive a separate dataway cycle generator and a separate talker. A talk address raises a one-cycle cycle request. The cycle generator reports the end of a cycle on `cycle_done`, which clears the one-shot clear and initialize latches.

Top module: `ibus_cmd_loader`

## Requirements
- R1: Reset, or `ifc` high at a clock edge, forces `mode_o` to idle and clears every register and latch: function, subaddress, station, write data, clear, initialize, inhibit, transfer mode and SRQ configuration. This holds from any state, and after it `rfd`=1 and `dac`=0.
- R2: `mode_o` is encoded as 0 idle, 1 listen, 2 talk and 3 serial poll.
  - Command 0x20+`dev_addr` (bits 6:0, ATN high) enters listen from any state.
  - Command 0x40+`dev_addr`, outside serial poll, enters talk and raises `cycle_req` for exactly one clock.
  - An address that belongs to another device has no effect.
- R3: Unlisten (0x3F) returns to idle only from listen. Untalk (0x5F) returns to idle only from talk. In any other state each of them leaves the mode unchanged.
- R4: Serial-poll-enable (0x18) enters serial poll. Serial-poll-disable (0x19) leaves serial poll for idle and raises `srq_clr` for one clock. A talk address received in serial poll neither changes the mode nor raises `cycle_req`.
- R5: Acceptor handshake:
  - While it is ready, the block drives `rfd`=1 and `dac`=0.
  - The clock edge that sees `dav`=1 captures the byte, and from then on `rfd`=0 and `dac`=1.
  - The edge after `dav` falls restores `rfd`=1 and `dac`=0.
  - `rfd` and `dac` are never high together.
- R6: The first data byte (ATN low) after entering listen is classified by bits 6:5. Class 00 is a function code, and bits 4:0 load the function register.
- R7: After a function byte, the next data bytes load, in this order:
  - subaddress from bits 3:0;
  - station from bits 4:0;
  - write data bits 7:0, then 15:8, then 23:16, each from the whole byte.
  
  Any further bytes are ignored.
- R8: A load that stops early keeps the earlier values of the registers it did not reach. Each listen address restarts the sequence at the first-byte position.
- R9: A first byte of class 01 is a control byte. Its bits act as follows:
  - bit 0 sets the clear latch;
  - bit 1 sets the initialize latch;
  - bit 2 sets inhibit;
  - bit 3 clears inhibit, and wins over bit 2.
  
  `cycle_done` clears the clear and initialize latches, but a set on the same edge wins. Data bytes after a control byte are ignored until the next listen address.
- R10: A first byte of class 11 is a setup byte. It is held pending and committed only when unlisten arrives in listen mode, and it never raises `cycle_req`.
  - With bit 4 = 0, bits 3:0 go to `xmode_o`.
  - With bit 4 = 1, bits 2:0 go to `srqcfg_o`, and the commit also clears inhibit.
- R11: The following data bytes change no register:
  - data bytes received while not in listen mode;
  - a first byte of class 10;
  - the bytes that follow a class 10 first byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ifc | input | 1 | Interface clear, synchronous |
| dev_addr | input | 5 | Bus address from switches |
| atn | input | 1 | Attention: byte is an interface command |
| dav | input | 1 | Controller data valid |
| din | input | 8 | Bus data byte |
| cycle_done | input | 1 | Crate cycle finished, clears one-shot latches |
| rfd | output | 1 | Ready for data |
| dac | output | 1 | Data accepted |
| mode_o | output | 2 | Interface mode |
| cycle_req | output | 1 | One-clock crate cycle request |
| srq_clr | output | 1 | One-clock request to drop pending service request |
| fn_o | output | 5 | Function code register |
| sub_o | output | 4 | Subaddress register |
| stn_o | output | 5 | Station register |
| wdata_o | output | 24 | Write data register |
| clr_o | output | 1 | Crate clear latch |
| init_o | output | 1 | Crate initialize latch |
| inh_o | output | 1 | Crate inhibit latch |
| xmode_o | output | 4 | Transfer mode latch |
| srqcfg_o | output | 3 | Service request configuration latch |

## Verification
Two functions of the clear latch can fall on the same edge: a control byte sets it while `cycle_done` from the cycle generator clears it. The bench raises `cycle_done` together with `dav` for a control byte that sets the clear bit, so both act on the single accept edge. It then expects the latch to read 1. A second case commits an SRQ setup byte on unlisten while inhibit is set. That commit changes the mode, the configuration and inhibit together, and the bench checks all three in the cycle after the unlisten is accepted.

// File: rtl/ibl_pkg.sv
package ibl_pkg;

  localparam int ADDR_W = 5;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_LISTEN = 2'd1,
    MODE_TALK   = 2'd2,
    MODE_SPOLL  = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    CLS_FUNC  = 2'b00,
    CLS_CTRL  = 2'b01,
    CLS_RSVD  = 2'b10,
    CLS_SETUP = 2'b11
  } cls_e;

  localparam logic [6:0] CMD_SPE = 7'h18;
  localparam logic [6:0] CMD_SPD = 7'h19;
  localparam logic [6:0] CMD_UNL = 7'h3F;
  localparam logic [6:0] CMD_UNT = 7'h5F;
  localparam logic [1:0] GRP_LSN = 2'b01;
  localparam logic [1:0] GRP_TLK = 2'b10;

  typedef struct packed {
    logic mla;
    logic mta;
    logic unl;
    logic unt;
    logic spe;
    logic spd;
  } cmd_hit_t;

  // Unlisten and untalk take priority over an own address that aliases them.
  function automatic cmd_hit_t decode_cmd(input logic [6:0] b,
                                          input logic [ADDR_W-1:0] addr);
    cmd_hit_t h;
    h.unl = (b == CMD_UNL);
    h.unt = (b == CMD_UNT);
    h.spe = (b == CMD_SPE);
    h.spd = (b == CMD_SPD);
    h.mla = !h.unl && (b[6:5] == GRP_LSN) && (b[4:0] == addr);
    h.mta = !h.unt && (b[6:5] == GRP_TLK) && (b[4:0] == addr);
    return h;
  endfunction

  function automatic cls_e classify(input logic [BYTE_W-1:0] b);
    return cls_e'(b[6:5]);
  endfunction

endpackage

// File: rtl/ibl_handshake.sv
module ibl_handshake (
  input  logic clk,
  input  logic rst_n,
  input  logic ifc,
  input  logic dav,
  output logic rfd,
  output logic dac,
  output logic acc_stb
);
  // hold = byte taken, waiting for the controller to drop dav
  logic hold;

  assign acc_stb = !hold && dav;
  assign rfd     = !hold;
  assign dac     = hold;

  always_ff @(posedge clk) begin
    if (!rst_n || ifc) hold <= 1'b0;
    else if (acc_stb)  hold <= 1'b1;
    else if (!dav)     hold <= 1'b0;
  end
endmodule

// File: rtl/ibl_mode_fsm.sv
module ibl_mode_fsm
  import ibl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ifc,
  input  logic              acc_stb,
  input  logic              atn,
  input  logic [6:0]        cmd,
  input  logic [ADDR_W-1:0] dev_addr,
  output mode_e             mode,
  output logic              cycle_req,
  output logic              srq_clr,
  output logic              ev_mla,
  output logic              ev_unl_lsn
);
  cmd_hit_t hit;
  logic     cmd_stb;
  logic     ev_mta;
  mode_e    mode_nx;

  assign hit        = decode_cmd(cmd, dev_addr);
  assign cmd_stb    = acc_stb && atn;
  assign ev_mla     = cmd_stb && hit.mla;
  assign ev_unl_lsn = cmd_stb && hit.unl && (mode == MODE_LISTEN);
  assign ev_mta     = cmd_stb && hit.mta && (mode != MODE_SPOLL);

  always_comb begin
    mode_nx = mode;
    if (cmd_stb) begin
      if (hit.spe)                              mode_nx = MODE_SPOLL;
      else if (hit.spd && mode == MODE_SPOLL)   mode_nx = MODE_IDLE;
      else if (hit.mla)                         mode_nx = MODE_LISTEN;
      else if (hit.unl && mode == MODE_LISTEN)  mode_nx = MODE_IDLE;
      else if (ev_mta)                          mode_nx = MODE_TALK;
      else if (hit.unt && mode == MODE_TALK)    mode_nx = MODE_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ifc) begin
      mode      <= MODE_IDLE;
      cycle_req <= 1'b0;
      srq_clr   <= 1'b0;
    end else begin
      mode      <= mode_nx;
      cycle_req <= ev_mta;
      srq_clr   <= cmd_stb && hit.spd && (mode == MODE_SPOLL);
    end
  end
endmodule

// File: rtl/ibl_loader.sv
module ibl_loader
  import ibl_pkg::*;
#(
  parameter int FN_W   = 5,
  parameter int SUB_W  = 4,
  parameter int STN_W  = 5,
  parameter int WBYTES = 3,
  parameter int XM_W   = 4,
  parameter int SC_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ifc,
  input  logic                     acc_stb,
  input  logic                     atn,
  input  logic [BYTE_W-1:0]        din,
  input  mode_e                    mode,
  input  logic                     ev_mla,
  input  logic                     ev_unl_lsn,
  input  logic                     cycle_done,
  output logic [FN_W-1:0]          fn_o,
  output logic [SUB_W-1:0]         sub_o,
  output logic [STN_W-1:0]         stn_o,
  output logic [WBYTES*BYTE_W-1:0] wdata_o,
  output logic                     clr_o,
  output logic                     init_o,
  output logic                     inh_o,
  output logic [XM_W-1:0]          xmode_o,
  output logic [SC_W-1:0]          srqcfg_o
);
  localparam int POS_SUB  = 1;
  localparam int POS_STN  = 2;
  localparam int POS_W0   = 3;
  localparam int POS_DONE = POS_W0 + WBYTES;
  localparam int IDX_W    = $clog2(POS_DONE + 1);
  localparam int SB_W     = 5;

  logic [IDX_W-1:0] idx;
  logic             dstb, first, ctl_stb, set_stb, commit;
  cls_e             cls;
  logic             set_pend;
  logic [SB_W-1:0]  set_byte;

  assign dstb    = acc_stb && !atn && (mode == MODE_LISTEN);
  assign first   = (idx == '0);
  assign cls     = classify(din);
  assign ctl_stb = dstb && first && (cls == CLS_CTRL);
  assign set_stb = dstb && first && (cls == CLS_SETUP);
  assign commit  = ev_unl_lsn && set_pend;

  // load position
  always_ff @(posedge clk) begin
    if (!rst_n || ifc) idx <= '0;
    else if (ev_mla)   idx <= '0;
    else if (dstb) begin
      if (first) idx <= (cls == CLS_FUNC) ? IDX_W'(POS_SUB) : IDX_W'(POS_DONE);
      else if (idx != IDX_W'(POS_DONE)) idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ifc) begin
      fn_o  <= '0;
      sub_o <= '0;
      stn_o <= '0;
    end else if (dstb) begin
      if (first && cls == CLS_FUNC)  fn_o  <= din[FN_W-1:0];
      if (idx == IDX_W'(POS_SUB))    sub_o <= din[SUB_W-1:0];
      if (idx == IDX_W'(POS_STN))    stn_o <= din[STN_W-1:0];
    end
  end

  for (genvar g = 0; g < WBYTES; g++) begin : g_wbyte
    always_ff @(posedge clk) begin
      if (!rst_n || ifc) wdata_o[g*BYTE_W +: BYTE_W] <= '0;
      else if (dstb && idx == IDX_W'(POS_W0 + g))
        wdata_o[g*BYTE_W +: BYTE_W] <= din;
    end
  end

  // one-shot crate latches: a set on the same edge beats cycle_done
  always_ff @(posedge clk) begin
    if (!rst_n || ifc) begin
      clr_o  <= 1'b0;
      init_o <= 1'b0;
    end else begin
      if (ctl_stb && din[0]) clr_o <= 1'b1;
      else if (cycle_done)   clr_o <= 1'b0;
      if (ctl_stb && din[1]) init_o <= 1'b1;
      else if (cycle_done)   init_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ifc)                inh_o <= 1'b0;
    else if (ctl_stb && din[3])       inh_o <= 1'b0;
    else if (ctl_stb && din[2])       inh_o <= 1'b1;
    else if (commit && set_byte[4])   inh_o <= 1'b0;
  end

  // setup byte waits for unlisten
  always_ff @(posedge clk) begin
    if (!rst_n || ifc) begin
      set_pend <= 1'b0;
      set_byte <= '0;
    end else if (set_stb) begin
      set_pend <= 1'b1;
      set_byte <= din[SB_W-1:0];
    end else if (ev_mla || ev_unl_lsn) begin
      set_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ifc) begin
      xmode_o  <= '0;
      srqcfg_o <= '0;
    end else if (commit) begin
      if (set_byte[4]) srqcfg_o <= set_byte[SC_W-1:0];
      else             xmode_o  <= set_byte[XM_W-1:0];
    end
  end
endmodule

// File: rtl/ibus_cmd_loader.sv
module ibus_cmd_loader
  import ibl_pkg::*;
#(
  parameter int FN_W   = 5,
  parameter int SUB_W  = 4,
  parameter int STN_W  = 5,
  parameter int WBYTES = 3,
  parameter int XM_W   = 4,
  parameter int SC_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ifc,
  input  logic [4:0]               dev_addr,
  input  logic                     atn,
  input  logic                     dav,
  input  logic [7:0]               din,
  input  logic                     cycle_done,
  output logic                     rfd,
  output logic                     dac,
  output logic [1:0]               mode_o,
  output logic                     cycle_req,
  output logic                     srq_clr,
  output logic [FN_W-1:0]          fn_o,
  output logic [SUB_W-1:0]         sub_o,
  output logic [STN_W-1:0]         stn_o,
  output logic [WBYTES*8-1:0]      wdata_o,
  output logic                     clr_o,
  output logic                     init_o,
  output logic                     inh_o,
  output logic [XM_W-1:0]          xmode_o,
  output logic [SC_W-1:0]          srqcfg_o
);
  logic  acc_stb;
  logic  ev_mla, ev_unl_lsn;
  mode_e mode;

  assign mode_o = mode;

  ibl_handshake u_hs (
    .clk(clk), .rst_n(rst_n), .ifc(ifc), .dav(dav),
    .rfd(rfd), .dac(dac), .acc_stb(acc_stb)
  );

  ibl_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .ifc(ifc), .acc_stb(acc_stb), .atn(atn),
    .cmd(din[6:0]), .dev_addr(dev_addr), .mode(mode),
    .cycle_req(cycle_req), .srq_clr(srq_clr),
    .ev_mla(ev_mla), .ev_unl_lsn(ev_unl_lsn)
  );

  ibl_loader #(
    .FN_W(FN_W), .SUB_W(SUB_W), .STN_W(STN_W),
    .WBYTES(WBYTES), .XM_W(XM_W), .SC_W(SC_W)
  ) u_ld (
    .clk(clk), .rst_n(rst_n), .ifc(ifc), .acc_stb(acc_stb), .atn(atn),
    .din(din), .mode(mode), .ev_mla(ev_mla), .ev_unl_lsn(ev_unl_lsn),
    .cycle_done(cycle_done),
    .fn_o(fn_o), .sub_o(sub_o), .stn_o(stn_o), .wdata_o(wdata_o),
    .clr_o(clr_o), .init_o(init_o), .inh_o(inh_o),
    .xmode_o(xmode_o), .srqcfg_o(srqcfg_o)
  );
endmodule

// File: rtl/ibl_checker.sv
module ibl_checker #(
  parameter int XM_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ifc,
  input logic            dav,
  input logic            rfd,
  input logic            dac,
  input logic            acc_stb,
  input logic [1:0]      mode_o,
  input logic            cycle_req,
  input logic            srq_clr,
  input logic            inh_o,
  input logic [XM_W-1:0] xmode_o
);
  p_hs_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rfd && dac));

  p_dac_after_dav_r5: assert property (@(posedge clk) disable iff (!rst_n || ifc)
    (rfd && dav) |=> dac);

  p_cycreq_talk_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_req |-> (mode_o == 2'd2));

  p_cycreq_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_req |=> !cycle_req);

  p_srqclr_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    srq_clr |-> (mode_o == 2'd0));

  p_ifc_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ifc |=> (mode_o == 2'd0 && !inh_o && xmode_o == '0 && rfd));

  p_xmode_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(xmode_o) |-> ($past(acc_stb) || $past(ifc)));
endmodule

bind ibus_cmd_loader ibl_checker #(.XM_W(XM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ifc(ifc), .dav(dav), .rfd(rfd), .dac(dac),
  .acc_stb(acc_stb), .mode_o(mode_o), .cycle_req(cycle_req),
  .srq_clr(srq_clr), .inh_o(inh_o), .xmode_o(xmode_o)
);

// File: tb/ibus_cmd_loader_bench.sv
module ibus_cmd_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] ADDR = 5'd5;
  localparam logic [7:0] MLA = 8'h25, MTA = 8'h45, UNL = 8'h3F, UNT = 8'h5F;

  logic clk = 0, rst_n = 0, ifc = 0, atn = 0, dav = 0, cycle_done = 0;
  logic [7:0] din = 0;
  logic rfd, dac, cycle_req, srq_clr, clr_o, init_o, inh_o;
  logic [1:0] mode_o;
  logic [4:0] fn_o, stn_o;
  logic [3:0] sub_o, xmode_o;
  logic [23:0] wdata_o;
  logic [2:0] srqcfg_o;

  int checks = 0, errors = 0, n_cyc = 0, n_sclr = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ibus_cmd_loader u_ibus_cmd_loader (
    .clk(clk), .rst_n(rst_n), .ifc(ifc), .dev_addr(ADDR), .atn(atn),
    .dav(dav), .din(din), .cycle_done(cycle_done), .rfd(rfd), .dac(dac),
    .mode_o(mode_o), .cycle_req(cycle_req), .srq_clr(srq_clr),
    .fn_o(fn_o), .sub_o(sub_o), .stn_o(stn_o), .wdata_o(wdata_o),
    .clr_o(clr_o), .init_o(init_o), .inh_o(inh_o),
    .xmode_o(xmode_o), .srqcfg_o(srqcfg_o)
  );

  always @(posedge clk) begin
    if (rst_n && cycle_req) n_cyc++;
    if (rst_n && srq_clr) n_sclr++;
  end

  typedef struct {
    string tag;
    int mode, fn, sub, stn, w, clr, init, inh, xm, sc, ncyc, nsclr;
  } exp_t;

  exp_t q[$];
  int m_mode, m_fn, m_sub, m_stn, m_w, m_clr, m_init, m_inh, m_xm, m_sc, m_ncyc, m_nsclr;

  task automatic cmp(string tag, string f, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, f, act, exp);
    end
  endtask

  task automatic snap(string tag);
    exp_t e;
    e.tag = tag; e.mode = m_mode; e.fn = m_fn; e.sub = m_sub; e.stn = m_stn;
    e.w = m_w; e.clr = m_clr; e.init = m_init; e.inh = m_inh; e.xm = m_xm;
    e.sc = m_sc; e.ncyc = m_ncyc; e.nsclr = m_nsclr;
    q.push_back(e);
  endtask

  // monitor: pops expected items and compares them with the ports
  initial begin
    forever begin
      exp_t e;
      wait (q.size() != 0);
      e = q.pop_front();
      cmp(e.tag, "mode", int'(mode_o), e.mode);
      cmp(e.tag, "fn", int'(fn_o), e.fn);
      cmp(e.tag, "sub", int'(sub_o), e.sub);
      cmp(e.tag, "stn", int'(stn_o), e.stn);
      cmp(e.tag, "wdata", int'(wdata_o), e.w);
      cmp(e.tag, "clr", int'(clr_o), e.clr);
      cmp(e.tag, "init", int'(init_o), e.init);
      cmp(e.tag, "inh", int'(inh_o), e.inh);
      cmp(e.tag, "xmode", int'(xmode_o), e.xm);
      cmp(e.tag, "srqcfg", int'(srqcfg_o), e.sc);
      cmp(e.tag, "cycle_req count", n_cyc, e.ncyc);
      cmp(e.tag, "srq_clr count", n_sclr, e.nsclr);
    end
  end

  task automatic send(bit a, logic [7:0] b, bit cd = 0, bit hk = 0);
    @(negedge clk);
    atn = a; din = b;
    while (!rfd) @(negedge clk);
    dav = 1; cycle_done = cd;
    @(negedge clk);
    cycle_done = 0;
    if (hk) begin  // R5 byte captured
      cmp("R5 accept", "rfd", int'(rfd), 0);
      cmp("R5 accept", "dac", int'(dac), 1);
    end
    dav = 0;
    @(negedge clk);
    if (hk) begin  // R5 ready again
      cmp("R5 release", "rfd", int'(rfd), 1);
      cmp("R5 release", "dac", int'(dac), 0);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    m_mode = 0; m_fn = 0; m_sub = 0; m_stn = 0; m_w = 0; m_clr = 0; m_init = 0;
    m_inh = 0; m_xm = 0; m_sc = 0; m_ncyc = 0; m_nsclr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    snap("R1 reset");
    cmp("R1 reset", "rfd", int'(rfd), 1);
    cmp("R1 reset", "dac", int'(dac), 0);

    send(1, MLA); m_mode = 1; snap("R2 listen address");
    send(0, 8'h0B, 0, 1); m_fn = 11; snap("R6 function byte");
    send(0, 8'h07); m_sub = 7;
    send(0, 8'h12); m_stn = 18;
    send(0, 8'hAA); send(0, 8'h55); send(0, 8'h3C); m_w = 24'h3C55AA;
    snap("R7 full sequence");
    send(0, 8'hFF); snap("R7 extra byte ignored");
    send(1, UNL); m_mode = 0; snap("R3 unlisten");
    send(1, UNT); snap("R3 untalk while idle");

    send(1, MTA); m_mode = 2; m_ncyc = 1; snap("R2 talk address");
    send(1, 8'h26); snap("R2 other device address");
    send(1, UNL); snap("R3 unlisten while talk");
    send(1, UNT); m_mode = 0; snap("R3 untalk");

    send(1, MLA); m_mode = 1;
    send(0, 8'h03); m_fn = 3; snap("R8 partial load");
    send(1, MLA); send(0, 8'h09); m_fn = 9; snap("R8 restart on listen");

    send(1, MLA); send(0, 8'h25); m_clr = 1; m_inh = 1; snap("R9 control byte");
    send(0, 8'h02); snap("R9 bytes after control ignored");
    @(negedge clk); cycle_done = 1; @(negedge clk); cycle_done = 0;
    m_clr = 0; snap("R9 cycle_done clears");
    send(1, MLA); send(0, 8'h21, 1); m_clr = 1; snap("R9 set wins over cycle_done");
    send(1, MLA); send(0, 8'h2C); m_inh = 0; snap("R9 inhibit clear wins");

    send(1, MLA); send(0, 8'h65); snap("R10 setup pending");
    send(1, UNL); m_mode = 0; m_xm = 5; snap("R10 transfer mode commit");
    send(1, MLA); send(0, 8'h24); m_mode = 1; m_inh = 1;
    send(1, UNL); m_mode = 0;
    send(1, MLA); send(0, 8'h73); m_mode = 1; snap("R10 srq setup pending");
    send(1, UNL); m_mode = 0; m_sc = 3; m_inh = 0; snap("R10 srq commit clears inhibit");

    send(0, 8'h0F); snap("R11 data while idle");
    send(1, MLA); m_mode = 1;
    send(0, 8'h4F); send(0, 8'h01); snap("R11 reserved class");
    send(1, UNL); m_mode = 0;

    send(1, 8'h18); m_mode = 3; snap("R4 poll enable");
    send(1, MTA); snap("R4 talk address in poll");
    send(1, 8'h19); m_mode = 0; m_nsclr = 1; snap("R4 poll disable");

    send(1, MTA); m_mode = 2; m_ncyc = 2;
    @(negedge clk); ifc = 1; @(negedge clk); ifc = 0;
    m_mode = 0; m_fn = 0; m_sub = 0; m_stn = 0; m_w = 0; m_clr = 0; m_init = 0;
    m_inh = 0; m_xm = 0; m_sc = 0;
    snap("R1 interface clear");
    cmp("R1 interface clear", "rfd", int'(rfd), 1);

    wait (q.size() == 0);
    #1;
    finish_run();
  end
endmodule